// File: doc/BRIEF.md
# Program Counter and Status Word Unit

This block keeps the 20-bit program counter and the 8-bit status word of a small 8/16-bit CPU core. After reset it reads two bytes over a simple byte-wide memory port. The byte at address 0 fills the low half of the start address and the byte at address 1 fills the high half. It then raises `ready`. From that point it follows the commands that decode and execute logic send to it.

In the running state the PC either steps forward by the length of the fetched instruction, loads a branch target, or loads a 16-bit interrupt vector. The status word holds the interrupt-enable, zero, auxiliary-carry, carry, bank-select and in-service priority bits. These bits change on flag writes, bank selects and interrupt enable or disable commands. The status word can also be saved through a byte push port and restored from a byte pop input, as the surrounding logic does for interrupts, breaks and stack operations.

Top module: `pc_status_unit`

## Requirements
- R1: While `rstN` is low, `pc` reads 0, `psw` reads 8'h06 (both priority bits set, every other bit clear), `ready` is 0, and `memRd` is 1 with `memAddr` 0.
- R2: After reset, the unit reads address 0 and then address 1. Each read waits for a one-cycle `memRdValid`. Byte 0 goes to pc[7:0], byte 1 goes to pc[15:8], and pc[19:16] is 0. `ready` rises at the edge that takes the second byte and stays at 1. `memRd` is 0 once `ready` is 1.
- R3: While `ready` is 0, every command input (advance, branch, interrupt acknowledge, enable, disable, flag, bank, push, pop) is ignored, and `psw` stays at 8'h06.
- R4: With `advance` high and no branch or acknowledge, `pc` grows by `instLen` (1 to 4) on the next edge, modulo 2^20.
- R5: `branchEn` loads `branchReg` when `branchSel` is 1 and `branchImm` when it is 0. A branch takes precedence over `advance`.
- R6: `intAck` loads `pc` with {4'b0, `intVector`} and clears IE (psw bit 7). It takes precedence over branch, advance and `eiCmd`.
- R7: `eiCmd` sets IE and `diCmd` clears it. If both arrive together, IE ends at 0. `irqOut` equals `irqReq` AND IE.
- R8: For each set bit of `flagWe`, the matching bit of `flagVal` is written: [2] to Z (psw bit 6), [1] to AC (psw bit 4), [0] to CY (psw bit 0). `bankWe` writes `bankSel[1]` to psw bit 5 and `bankSel[0]` to psw bit 3. `bank` reads {psw[5], psw[3]}. Bits 2:1 change only through reset or a restore.
- R9: When `ready` and either `pushPsw` or `intAck` is high, `pswPushValid` is 1 in the same cycle, and `pswPushData` carries the status word as it was before that cycle's updates.
- R10: `popEn` loads `psw` with `popData` on the next edge. It overrides any flag, bank, enable, disable or acknowledge change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| memRd | output | 1 | Vector read request |
| memAddr | output | 20 | Vector read address |
| memRdata | input | 8 | Read data byte |
| memRdValid | input | 1 | Read data valid, one cycle |
| ready | output | 1 | Vector fetched, unit running |
| advance | input | 1 | Step PC by instruction length |
| instLen | input | 3 | Instruction length, 1 to 4 bytes |
| branchEn | input | 1 | Load branch target |
| branchSel | input | 1 | 1: register target, 0: immediate target |
| branchImm | input | 20 | Immediate branch target |
| branchReg | input | 20 | Register branch target |
| intAck | input | 1 | Interrupt acknowledged |
| intVector | input | 16 | Interrupt vector address |
| eiCmd | input | 1 | Enable interrupts |
| diCmd | input | 1 | Disable interrupts |
| flagWe | input | 3 | Flag write enables {Z, AC, CY} |
| flagVal | input | 3 | Flag values {Z, AC, CY} |
| bankWe | input | 1 | Bank select write |
| bankSel | input | 2 | New bank index |
| pushPsw | input | 1 | Push status word command |
| pswPushValid | output | 1 | Status byte to be stored |
| pswPushData | output | 8 | Status byte being pushed |
| popEn | input | 1 | Restore status word |
| popData | input | 8 | Restored status byte |
| irqReq | input | 1 | Maskable interrupt request |
| irqOut | output | 1 | Request passed by IE |
| pc | output | 20 | Program counter |
| psw | output | 8 | Status word |
| bank | output | 2 | Selected register bank |

## Verification
The PC is stepped by each length from 1 to 4, which shows whether the length is added or a fixed step is used. A step past 20'hFFFFE shows whether the counter wraps inside 20 bits. Branches with both values of `branchSel`, and with `advance` also high, show whether the right source is chosen and whether the branch wins. The acknowledge is sent together with a branch and an enable command, which shows whether vector, IE clear and push data follow the stated order. Flag, bank and pop writes are sent alone and mixed together, which shows whether each write enable touches only its own bit and whether a restore takes precedence.

// File: rtl/pcsu_pkg.sv
package pcsu_pkg;
  localparam int PSW_W   = 8;
  localparam int IE_B    = 7;
  localparam int Z_B     = 6;
  localparam int RBS1_B  = 5;
  localparam int AC_B    = 4;
  localparam int RBS0_B  = 3;
  localparam int CY_B    = 0;
  localparam logic [PSW_W-1:0] PSW_RST = 8'h06;
  localparam int FLAG_N  = 3;

  // flag write index -> status word bit (0: CY, 1: AC, 2: Z)
  function automatic int flagPos(input int idx);
    case (idx)
      0:       return CY_B;
      1:       return AC_B;
      default: return Z_B;
    endcase
  endfunction

  typedef enum logic [1:0] {ST_VLO, ST_VHI, ST_RUN} seqState_t;

  typedef struct packed {
    logic vecLo;
    logic vecHi;
    logic pcStep;
    logic pcBranch;
    logic pcVector;
    logic pswRestore;
    logic ieClr;
    logic ieSet;
    logic flagWr;
    logic bankWr;
  } dpStrobe_t;
endpackage

// File: rtl/pcsu_ctrl.sv
module pcsu_ctrl
  import pcsu_pkg::*;
#(
  parameter int PC_W = 20
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            memRdValid,
  input  logic            advance,
  input  logic            branchEn,
  input  logic            intAck,
  input  logic            eiCmd,
  input  logic            diCmd,
  input  logic            bankWe,
  input  logic            pushPsw,
  input  logic            popEn,
  output dpStrobe_t       strb,
  output logic            memRd,
  output logic [PC_W-1:0] memAddr,
  output logic            ready,
  output logic            pswPushValid
);
  seqState_t state;
  logic run;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_VLO;
    end else begin
      case (state)
        ST_VLO:  if (memRdValid) state <= ST_VHI;
        ST_VHI:  if (memRdValid) state <= ST_RUN;
        default: state <= ST_RUN;
      endcase
    end
  end

  assign run     = (state == ST_RUN);
  assign ready   = run;
  assign memRd   = !run;
  assign memAddr = (state == ST_VHI) ? PC_W'(1) : '0;

  always_comb begin
    strb            = '0;
    strb.vecLo      = (state == ST_VLO) && memRdValid;
    strb.vecHi      = (state == ST_VHI) && memRdValid;
    strb.pcVector   = run && intAck;
    strb.pcBranch   = run && branchEn && !intAck;
    strb.pcStep     = run && advance && !branchEn && !intAck;
    strb.pswRestore = run && popEn;
    strb.ieClr      = run && !popEn && (intAck || diCmd);
    strb.ieSet      = run && !popEn && eiCmd && !intAck && !diCmd;
    strb.flagWr     = run && !popEn;
    strb.bankWr     = run && !popEn && bankWe;
  end

  assign pswPushValid = run && (pushPsw || intAck);
endmodule

// File: rtl/pcsu_dp.sv
module pcsu_dp
  import pcsu_pkg::*;
#(
  parameter int PC_W  = 20,
  parameter int VEC_W = 16,
  parameter int LEN_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strb,
  input  logic [7:0]         memRdata,
  input  logic [LEN_W-1:0]   instLen,
  input  logic               branchSel,
  input  logic [PC_W-1:0]    branchImm,
  input  logic [PC_W-1:0]    branchReg,
  input  logic [VEC_W-1:0]   intVector,
  input  logic [FLAG_N-1:0]  flagWe,
  input  logic [FLAG_N-1:0]  flagVal,
  input  logic [1:0]         bankSel,
  input  logic [PSW_W-1:0]   popData,
  output logic [PC_W-1:0]    pc,
  output logic [PSW_W-1:0]   psw
);
  localparam int HI_W = PC_W - VEC_W;

  logic [PC_W-1:0]  pcQ, pcN;
  logic [PSW_W-1:0] pswQ, pswN;
  logic [PSW_W-1:0] flagMask, flagBits;

  // Per-flag write mask and data, placed at each flag's bit position
  generate
    for (genvar g = 0; g < FLAG_N; g++) begin : gFlag
      localparam int POS = flagPos(g);
      assign flagMask[POS] = flagWe[g];
      assign flagBits[POS] = flagVal[g];
    end
  endgenerate
  assign flagMask[IE_B]   = 1'b0;
  assign flagMask[RBS1_B] = 1'b0;
  assign flagMask[RBS0_B] = 1'b0;
  assign flagMask[2:1]    = 2'b00;
  assign flagBits[IE_B]   = 1'b0;
  assign flagBits[RBS1_B] = 1'b0;
  assign flagBits[RBS0_B] = 1'b0;
  assign flagBits[2:1]    = 2'b00;

  always_comb begin
    pcN = pcQ;
    if (strb.vecLo)         pcN[7:0] = memRdata;
    else if (strb.vecHi)    pcN = {{HI_W{1'b0}}, memRdata, pcQ[7:0]};
    else if (strb.pcVector) pcN = {{HI_W{1'b0}}, intVector};
    else if (strb.pcBranch) pcN = branchSel ? branchReg : branchImm;
    else if (strb.pcStep)   pcN = pcQ + PC_W'(instLen);
  end

  always_comb begin
    pswN = pswQ;
    if (strb.pswRestore) begin
      pswN = popData;
    end else begin
      if (strb.flagWr) pswN = (pswQ & ~flagMask) | (flagBits & flagMask);
      if (strb.bankWr) begin
        pswN[RBS1_B] = bankSel[1];
        pswN[RBS0_B] = bankSel[0];
      end
      if (strb.ieClr)      pswN[IE_B] = 1'b0;
      else if (strb.ieSet) pswN[IE_B] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ  <= '0;
      pswQ <= PSW_RST;
    end else begin
      pcQ  <= pcN;
      pswQ <= pswN;
    end
  end

  assign pc  = pcQ;
  assign psw = pswQ;
endmodule

// File: rtl/pc_status_unit.sv
module pc_status_unit
  import pcsu_pkg::*;
#(
  parameter int PC_W  = 20,
  parameter int VEC_W = 16,
  parameter int LEN_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  output logic               memRd,
  output logic [PC_W-1:0]    memAddr,
  input  logic [7:0]         memRdata,
  input  logic               memRdValid,
  output logic               ready,
  input  logic               advance,
  input  logic [LEN_W-1:0]   instLen,
  input  logic               branchEn,
  input  logic               branchSel,
  input  logic [PC_W-1:0]    branchImm,
  input  logic [PC_W-1:0]    branchReg,
  input  logic               intAck,
  input  logic [VEC_W-1:0]   intVector,
  input  logic               eiCmd,
  input  logic               diCmd,
  input  logic [FLAG_N-1:0]  flagWe,
  input  logic [FLAG_N-1:0]  flagVal,
  input  logic               bankWe,
  input  logic [1:0]         bankSel,
  input  logic               pushPsw,
  output logic               pswPushValid,
  output logic [PSW_W-1:0]   pswPushData,
  input  logic               popEn,
  input  logic [PSW_W-1:0]   popData,
  input  logic               irqReq,
  output logic               irqOut,
  output logic [PC_W-1:0]    pc,
  output logic [PSW_W-1:0]   psw,
  output logic [1:0]         bank
);
  dpStrobe_t strb;

  pcsu_ctrl #(.PC_W(PC_W)) ctrlI (
    .clk(clk), .rstN(rstN), .memRdValid(memRdValid), .advance(advance),
    .branchEn(branchEn), .intAck(intAck), .eiCmd(eiCmd), .diCmd(diCmd),
    .bankWe(bankWe), .pushPsw(pushPsw), .popEn(popEn), .strb(strb),
    .memRd(memRd), .memAddr(memAddr), .ready(ready),
    .pswPushValid(pswPushValid)
  );

  pcsu_dp #(.PC_W(PC_W), .VEC_W(VEC_W), .LEN_W(LEN_W)) dpI (
    .clk(clk), .rstN(rstN), .strb(strb), .memRdata(memRdata),
    .instLen(instLen), .branchSel(branchSel), .branchImm(branchImm),
    .branchReg(branchReg), .intVector(intVector), .flagWe(flagWe),
    .flagVal(flagVal), .bankSel(bankSel), .popData(popData),
    .pc(pc), .psw(psw)
  );

  assign pswPushData = psw;
  assign irqOut      = irqReq && psw[IE_B];
  assign bank        = {psw[RBS1_B], psw[RBS0_B]};
endmodule

// File: rtl/pcsu_chk.sv
module pcsu_chk #(
  parameter int PC_W  = 20,
  parameter int LEN_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             ready,
  input logic             advance,
  input logic [LEN_W-1:0] instLen,
  input logic             branchEn,
  input logic             branchSel,
  input logic [PC_W-1:0]  branchImm,
  input logic [PC_W-1:0]  branchReg,
  input logic             intAck,
  input logic             pushPsw,
  input logic             pswPushValid,
  input logic             popEn,
  input logic [7:0]       popData,
  input logic             irqOut,
  input logic [PC_W-1:0]  pc,
  input logic [7:0]       psw
);
  a_r2_ready_sticks: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> pc[PC_W-1:16] == '0);
  a_r3_psw_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> $stable(psw));
  a_r4_step: assert property (@(posedge clk) disable iff (!rstN)
    (ready && advance && !branchEn && !intAck) |=>
      pc == $past(pc) + PC_W'($past(instLen)));
  a_r5_branch: assert property (@(posedge clk) disable iff (!rstN)
    (ready && branchEn && !intAck) |=>
      pc == ($past(branchSel) ? $past(branchReg) : $past(branchImm)));
  a_r6_ack_ie: assert property (@(posedge clk) disable iff (!rstN)
    (ready && intAck && !popEn) |=> !psw[7]);
  a_r7_mask: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> psw[7]);
  a_r9_push: assert property (@(posedge clk) disable iff (!rstN)
    (ready && (pushPsw || intAck)) |-> pswPushValid);
  a_r10_restore: assert property (@(posedge clk) disable iff (!rstN)
    (ready && popEn) |=> psw == $past(popData));
endmodule

bind pc_status_unit pcsu_chk #(.PC_W(PC_W), .LEN_W(LEN_W)) chkI (
  .clk(clk), .rstN(rstN), .ready(ready), .advance(advance),
  .instLen(instLen), .branchEn(branchEn), .branchSel(branchSel),
  .branchImm(branchImm), .branchReg(branchReg), .intAck(intAck),
  .pushPsw(pushPsw), .pswPushValid(pswPushValid), .popEn(popEn),
  .popData(popData), .irqOut(irqOut), .pc(pc), .psw(psw)
);

// File: tb/pc_status_unit_test.sv
module pc_status_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic memRd, ready, pswPushValid, irqOut;
  logic [PC_W-1:0] memAddr, pc;
  logic [7:0] memRdata = 8'h00, pswPushData, psw;
  logic memRdValid = 1'b0;
  logic advance = 0, branchEn = 0, branchSel = 0, intAck = 0;
  logic eiCmd = 0, diCmd = 0, bankWe = 0, pushPsw = 0, popEn = 0, irqReq = 0;
  logic [2:0] instLen = 3'd1, flagWe = 3'b0, flagVal = 3'b0;
  logic [PC_W-1:0] branchImm = '0, branchReg = '0;
  logic [15:0] intVector = '0;
  logic [1:0] bankSel = 2'b0, bank;
  logic [7:0] popData = 8'h00;

  pc_status_unit uut (
    .clk(clk), .rstN(rstN), .memRd(memRd), .memAddr(memAddr),
    .memRdata(memRdata), .memRdValid(memRdValid), .ready(ready),
    .advance(advance), .instLen(instLen), .branchEn(branchEn),
    .branchSel(branchSel), .branchImm(branchImm), .branchReg(branchReg),
    .intAck(intAck), .intVector(intVector), .eiCmd(eiCmd), .diCmd(diCmd),
    .flagWe(flagWe), .flagVal(flagVal), .bankWe(bankWe), .bankSel(bankSel),
    .pushPsw(pushPsw), .pswPushValid(pswPushValid), .pswPushData(pswPushData),
    .popEn(popEn), .popData(popData), .irqReq(irqReq), .irqOut(irqOut),
    .pc(pc), .psw(psw), .bank(bank)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Byte memory holding the start address: 0 -> 8'h34, 1 -> 8'h12
  always @(posedge clk) begin
    memRdValid <= memRd && !memRdValid;
    memRdata   <= memAddr[0] ? 8'h12 : 8'h34;
  end

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [PC_W-1:0] pcE;
    logic [7:0] pswE;
    string req;
  } exp_t;
  exp_t q[$];

  // Monitor: compares registered state a quarter period after each edge
  always @(posedge clk) begin
    exp_t e;
    #(CLK_PERIOD/4);
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(pc === e.pcE, e.req, "pc", 32'(pc), 32'(e.pcE));
      chk(psw === e.pswE, e.req, "psw", 32'(psw), 32'(e.pswE));
      chk(bank === {e.pswE[5], e.pswE[3]}, e.req, "bank", 32'(bank),
          32'({e.pswE[5], e.pswE[3]}));
    end
  end

  logic [PC_W-1:0] mdlPc;
  logic [7:0] mdlPsw;

  task automatic clearCmds();
    advance = 0; branchEn = 0; intAck = 0; eiCmd = 0; diCmd = 0;
    flagWe = 0; bankWe = 0; pushPsw = 0; popEn = 0; irqReq = 0;
  endtask

  // Driver: inputs already set at a negedge; checks same-cycle outputs,
  // queues the expected state for after the next edge.
  task automatic cycle(input string req);
    logic [7:0] nPsw;
    #1;
    chk(pswPushValid === (intAck | pushPsw), req, "pushValid",
        32'(pswPushValid), 32'(intAck | pushPsw));
    if (intAck | pushPsw)
      chk(pswPushData === mdlPsw, req, "pushData", 32'(pswPushData), 32'(mdlPsw));
    chk(irqOut === (irqReq & mdlPsw[7]), req, "irqOut", 32'(irqOut),
        32'(irqReq & mdlPsw[7]));
    if (intAck)        mdlPc = {4'h0, intVector};
    else if (branchEn) mdlPc = branchSel ? branchReg : branchImm;
    else if (advance)  mdlPc = mdlPc + PC_W'(instLen);
    nPsw = mdlPsw;
    if (popEn) nPsw = popData;
    else begin
      if (flagWe[2]) nPsw[6] = flagVal[2];
      if (flagWe[1]) nPsw[4] = flagVal[1];
      if (flagWe[0]) nPsw[0] = flagVal[0];
      if (bankWe) begin nPsw[5] = bankSel[1]; nPsw[3] = bankSel[0]; end
      if (intAck || diCmd) nPsw[7] = 1'b0;
      else if (eiCmd)      nPsw[7] = 1'b1;
    end
    mdlPsw = nPsw;
    q.push_back('{pcE: mdlPc, pswE: mdlPsw, req: req});
    @(negedge clk);
    clearCmds();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (run): actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pc === '0, "R1", "pc", 32'(pc), 0);
    chk(psw === 8'h06, "R1", "psw", 32'(psw), 32'h06);
    chk(ready === 1'b0, "R1", "ready", 32'(ready), 0);
    chk(memRd === 1'b1 && memAddr === '0, "R1", "memRd/addr",
        {memRd, 11'b0, memAddr}, 32'h8000_0000);
    // R3: commands held high through the vector fetch
    advance = 1; instLen = 3'd4; branchEn = 1; branchImm = 20'hABCDE;
    eiCmd = 1; popEn = 1; popData = 8'hFF; flagWe = 3'b111; flagVal = 3'b111;
    bankWe = 1; bankSel = 2'b11; intAck = 1; intVector = 16'h5555;
    rstN = 1;
    for (int i = 0; i < 20 && !ready; i++) begin
      @(negedge clk);
      chk(psw === 8'h06, "R3", "psw during fetch", 32'(psw), 32'h06);
    end
    clearCmds();
    // R2: start address assembled, ready holds
    chk(ready === 1'b1, "R2", "ready", 32'(ready), 1);
    chk(pc === 20'h01234, "R2", "pc vector", 32'(pc), 32'h01234);
    chk(memRd === 1'b0, "R2", "memRd after fetch", 32'(memRd), 0);
    mdlPc = 20'h01234; mdlPsw = 8'h06;

    // R4: each instruction length
    for (int l = 1; l <= 4; l++) begin
      advance = 1; instLen = 3'(l); cycle("R4");
    end
    // R5: immediate, register, branch beating advance
    branchEn = 1; branchSel = 0; branchImm = 20'hFFFFE; cycle("R5");
    advance = 1; instLen = 3'd4; cycle("R4 wrap");
    branchEn = 1; branchSel = 1; branchReg = 20'h8A0F3; branchImm = 20'h11111;
    cycle("R5");
    branchEn = 1; branchSel = 0; branchImm = 20'h22222; advance = 1; instLen = 3'd2;
    cycle("R5 over advance");
    // R7: enable, mask, disable, both together
    irqReq = 1; cycle("R7 masked");
    eiCmd = 1; cycle("R7");
    irqReq = 1; cycle("R7 passed");
    diCmd = 1; cycle("R7");
    eiCmd = 1; cycle("R7");
    eiCmd = 1; diCmd = 1; cycle("R7 both");
    eiCmd = 1; cycle("R7");
    // R6 and R9: acknowledge beats branch, advance and enable; push old value
    intAck = 1; intVector = 16'hBEEF; branchEn = 1; branchImm = 20'h33333;
    advance = 1; eiCmd = 1; cycle("R6");
    // R8: flags one at a time and together, banks
    flagWe = 3'b100; flagVal = 3'b111; cycle("R8 Z");
    flagWe = 3'b011; flagVal = 3'b011; cycle("R8 AC CY");
    flagWe = 3'b001; flagVal = 3'b000; cycle("R8 CY");
    bankWe = 1; bankSel = 2'b10; cycle("R8 bank");
    bankWe = 1; bankSel = 2'b01; cycle("R8 bank");
    // R9: plain push
    pushPsw = 1; cycle("R9");
    // R10: restore overrides flag, bank, enable, acknowledge
    popEn = 1; popData = 8'hA9; flagWe = 3'b111; flagVal = 3'b000;
    bankWe = 1; bankSel = 2'b00; eiCmd = 1; cycle("R10");
    popEn = 1; popData = 8'h00; intAck = 1; intVector = 16'h0100; cycle("R10 ack");
    // R8: priority bits untouched by writes after restore
    flagWe = 3'b111; flagVal = 3'b111; bankWe = 1; bankSel = 2'b11; eiCmd = 1;
    cycle("R8 isp kept");
    popEn = 1; popData = 8'h06; cycle("R10");
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule